// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time

This block sits between a controller and the two gate drivers of one half-bridge. It takes a high-side and a low-side command bit and produces one drive-enable bit for each of the two power switches. It never lets both switches conduct together. Between one switch turning off and the other turning on it inserts a fixed dead time, counted in clock cycles.

The block also applies the supply rules of the two driver halves. An undervoltage on the low-voltage supply turns both switches off for as long as it lasts. An undervoltage on the floating high-side supply turns off only the high switch. The high switch then stays off after that supply recovers, until the high command shows a new rising edge. A freeze request holds both outputs where they are. A hard-shutdown request turns both outputs off at once and is not remembered.

The command bits pass through a multi-flop synchroniser. The supply flags and the freeze and shutdown requests arrive already synchronous. The shutdown and undervoltage flags act on the outputs combinationally, so they take effect in the same cycle.

Top module: `hb_interlock`

## Requirements
- R1: When both synchronised commands are high, both outputs go low and stay low. When only one command remains high, its output resumes.
- R2: An output rises only after the opposite output has been low for at least DEAD_CYCLES clock edges. On a direct handover, where one command falls in the same cycle as the other rises, both outputs are low at exactly DEAD_CYCLES+1 consecutive sample points.
- R3: With the opposite command low and the dead time satisfied, each output follows its own command: 1 turns it on and 0 turns it off.
- R4: While uv_lo is high, both outputs are low from the same cycle onward. After uv_lo falls, the outputs follow the commands again within two cycles, with no clearing action needed.
- R5: While uv_hi is high, drv_hi is low from the same cycle onward, and drv_lo keeps following cmd_lo.
- R6: After uv_hi falls, drv_hi stays low even when cmd_hi is high, until cmd_hi rises after uv_hi has gone low. A rising edge of cmd_hi while uv_hi is high does not re-enable the high side.
- R7: While freeze is high, and no shutdown or undervoltage is active, both outputs keep their values whatever the commands do. After freeze falls, the outputs follow the commands.
- R8: While shutdown is high, both outputs are low from the same cycle onward, even when freeze is high. After shutdown and freeze fall, the outputs follow the commands with no clearing action.
- R9: A command change reaches its output just after the third rising clock edge that follows the change, when the dead time does not hold it back. Two edges are spent in the synchroniser and one in the output register.
- R10: During reset both outputs are low. Because the dead-time counters start cleared, neither output can rise within DEAD_CYCLES edges after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_hi | input | 1 | High-side on command (asynchronous) |
| cmd_lo | input | 1 | Low-side on command (asynchronous) |
| uv_lo | input | 1 | Low-voltage supply undervoltage, active high |
| uv_hi | input | 1 | Floating high-side supply undervoltage, active high |
| freeze | input | 1 | Hold both outputs at their current values, active high |
| shutdown | input | 1 | Hard shutdown of both outputs, active high |
| drv_hi | output | 1 | High-side switch drive enable |
| drv_lo | output | 1 | Low-side switch drive enable |

## Verification
Directed single-command pulses on each side, checked at every sample point, separate synchroniser latency from dead-time delay. Direct handovers in both directions count the overlap-free gap exactly, so an off-by-one in the counter or a missing interlock term shows up. Overlapping commands show whether the interlock or the dead time keeps the outputs off. Sequences of supply flags, freeze and shutdown separate latched from unlatched behaviour: the high side needs a fresh command edge after its own undervoltage, while the other conditions clear by themselves.

// File: rtl/hb_pkg.sv
package hb_pkg;

  localparam int unsigned SIDE_LO = 0;
  localparam int unsigned SIDE_HI = 1;
  localparam int unsigned NUM_SIDES = 2;

  typedef struct packed {
    logic req;   // interlocked on request for this side
    logic kill;  // immediate forced off
    logic hold;  // freeze: keep current state
  } side_ctl_t;

endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_nxt;
      if (g == 0) begin : g_first
        always_comb stage_nxt = d_in;
      end else begin : g_rest
        always_comb stage_nxt = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_nxt;
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
  parameter int unsigned DEAD_CYCLES = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic other_on,
  output logic gap_ok
);

  localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEAD_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = other_on || (cnt_q != CNT_MAX);
    cnt_nxt = other_on ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign gap_ok = (cnt_q == CNT_MAX);

endmodule

// File: rtl/hb_side.sv
module hb_side
  import hb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  side_ctl_t ctl,
  input  logic      gap_ok,
  output logic      drv
);

  logic on_q;
  logic on_nxt;
  logic on_en;

  always_comb begin
    on_en  = ctl.kill || !ctl.hold;
    on_nxt = !ctl.kill && ctl.req && gap_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_q <= 1'b0;
    else if (on_en) on_q <= on_nxt;
  end

  assign drv = on_q && !ctl.kill;

endmodule

// File: rtl/hb_rearm.sv
module hb_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_s,
  input  logic uv,
  output logic armed
);

  logic prev_q;
  logic armed_q;
  logic armed_nxt;
  logic armed_en;
  logic rise;

  always_comb begin
    rise      = cmd_s && !prev_q;
    armed_en  = uv || rise;
    armed_nxt = !uv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      prev_q <= cmd_s;
      if (armed_en) armed_q <= armed_nxt;
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 33,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic uv_lo,
  input  logic uv_hi,
  input  logic freeze,
  input  logic shutdown,
  output logic drv_hi,
  output logic drv_lo
);

  logic                 rst_core_n;
  logic [NUM_SIDES-1:0] cmd_s;
  logic                 hi_armed;
  logic [NUM_SIDES-1:0] drv_v;
  logic [NUM_SIDES-1:0] gap_ok;
  side_ctl_t            ctl [NUM_SIDES];

  hb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  hb_sync #(.WIDTH(NUM_SIDES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_in  ({cmd_hi, cmd_lo}),
    .d_out (cmd_s)
  );

  hb_rearm u_rearm (
    .clk   (clk),
    .rst_n (rst_core_n),
    .cmd_s (cmd_s[SIDE_HI]),
    .uv    (uv_hi),
    .armed (hi_armed)
  );

  always_comb begin
    ctl[SIDE_HI].req  = cmd_s[SIDE_HI] && !cmd_s[SIDE_LO] && hi_armed;
    ctl[SIDE_HI].kill = shutdown || uv_lo || uv_hi;
    ctl[SIDE_HI].hold = freeze;
    ctl[SIDE_LO].req  = cmd_s[SIDE_LO] && !cmd_s[SIDE_HI];
    ctl[SIDE_LO].kill = shutdown || uv_lo;
    ctl[SIDE_LO].hold = freeze;
  end

  genvar s;
  generate
    for (s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam int unsigned OTHER = NUM_SIDES - 1 - s;
      hb_gap_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .other_on (drv_v[OTHER]),
        .gap_ok   (gap_ok[s])
      );
      hb_side u_side (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .ctl    (ctl[s]),
        .gap_ok (gap_ok[s]),
        .drv    (drv_v[s])
      );
    end
  endgenerate

  assign drv_hi = drv_v[SIDE_HI];
  assign drv_lo = drv_v[SIDE_LO];

endmodule

// File: rtl/hb_interlock_chk.sv
module hb_interlock_chk #(
  parameter int unsigned DEAD_CYCLES = 33
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_hi,
  input logic uv_lo,
  input logic uv_hi,
  input logic freeze,
  input logic shutdown,
  input logic drv_hi,
  input logic drv_lo
);

  int unsigned lo_off_cnt;
  int unsigned hi_off_cnt;
  logic        hold_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_off_cnt <= 0;
      hi_off_cnt <= 0;
    end else begin
      lo_off_cnt <= drv_lo ? 0 : ((lo_off_cnt > DEAD_CYCLES) ? lo_off_cnt : lo_off_cnt + 1);
      hi_off_cnt <= drv_hi ? 0 : ((hi_off_cnt > DEAD_CYCLES) ? hi_off_cnt : hi_off_cnt + 1);
    end
  end

  assign hold_ok = freeze && !shutdown && !uv_lo && !uv_hi;

  // R1
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  // R2
  p_dead_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> (lo_off_cnt >= DEAD_CYCLES));
  p_dead_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> (hi_off_cnt >= DEAD_CYCLES));

  // R4
  p_uvlo_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_lo |-> (!drv_hi && !drv_lo));

  // R5
  p_uvhi_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uv_hi |-> !drv_hi);

  // R7
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ok && $past(hold_ok)) |-> ($stable(drv_hi) && $stable(drv_lo)));

  // R8
  p_shdn_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!drv_hi && !drv_lo));

  // R9
  p_sync_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> $past(cmd_hi, 3));

endmodule

bind hb_interlock hb_interlock_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_hi   (cmd_hi),
  .uv_lo    (uv_lo),
  .uv_hi    (uv_hi),
  .freeze   (freeze),
  .shutdown (shutdown),
  .drv_hi   (drv_hi),
  .drv_lo   (drv_lo)
);

// File: tb/hb_interlock_tb.sv
module hb_interlock_tb;

  localparam int unsigned DT = 33;

  logic clk;
  logic rst_n;
  logic cmd_hi, cmd_lo, uv_lo, uv_hi, freeze, shutdown;
  logic drv_hi, drv_lo;

  int n_chk;
  int n_bad;
  bit done;

  hb_interlock #(.DEAD_CYCLES(DT), .SYNC_STAGES(2)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_hi   (cmd_hi),
    .cmd_lo   (cmd_lo),
    .uv_lo    (uv_lo),
    .uv_hi    (uv_hi),
    .freeze   (freeze),
    .shutdown (shutdown),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_r10();
    rst_n = 1'b0; cmd_hi = 1'b1; cmd_lo = 1'b0; uv_lo = 1'b0; uv_hi = 1'b0;
    freeze = 1'b0; shutdown = 1'b0;
    wait_neg(4);
    chk("R10 hi low in reset", drv_hi, 0);
    chk("R10 lo low in reset", drv_lo, 0);
    rst_n = 1'b1;
    wait_neg(DT);
    chk("R10 hi held off by dead time after reset", drv_hi, 0);
    cmd_hi = 1'b0;
    wait_neg(50);
  endtask

  task automatic t_follow_r3_r9();
    cmd_hi = 1'b1;
    wait_neg(1); chk("R9 hi after 1 edge", drv_hi, 0);
    wait_neg(1); chk("R9 hi after 2 edges", drv_hi, 0);
    wait_neg(1); chk("R9 hi after 3 edges", drv_hi, 1);
    chk("R3 lo stays off", drv_lo, 0);
    cmd_hi = 1'b0;
    wait_neg(2); chk("R9 hi off not before 3 edges", drv_hi, 1);
    wait_neg(1); chk("R3 hi follows low", drv_hi, 0);
    wait_neg(50);
    cmd_lo = 1'b1;
    wait_neg(3); chk("R3 lo follows high", drv_lo, 1);
    cmd_lo = 1'b0;
    wait_neg(3); chk("R3 lo follows low", drv_lo, 0);
    wait_neg(50);
  endtask

  task automatic t_handover_r2(input bit to_hi);
    int both_low;
    int both_high;
    cmd_hi = !to_hi; cmd_lo = to_hi;
    wait_neg(50);
    chk("R2 start side on", to_hi ? drv_lo : drv_hi, 1);
    cmd_hi = to_hi; cmd_lo = !to_hi;
    both_low = 0; both_high = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!drv_hi && !drv_lo) both_low++;
      if (drv_hi && drv_lo) both_high++;
    end
    chk("R2 dead gap length", both_low, DT + 1);
    chk("R2 no overlap", both_high, 0);
    chk("R2 new side on", to_hi ? drv_hi : drv_lo, 1);
    cmd_hi = 1'b0; cmd_lo = 1'b0;
    wait_neg(50);
  endtask

  task automatic t_both_r1();
    cmd_hi = 1'b1;
    wait_neg(50);
    cmd_lo = 1'b1;
    wait_neg(5);
    chk("R1 hi off when both high", drv_hi, 0);
    chk("R1 lo off when both high", drv_lo, 0);
    wait_neg(50);
    chk("R1 lo still off", drv_lo, 0);
    cmd_lo = 1'b0;
    wait_neg(10);
    chk("R1 hi resumes", drv_hi, 1);
    cmd_hi = 1'b0;
    wait_neg(50);
  endtask

  task automatic t_uvlo_r4();
    cmd_hi = 1'b1;
    wait_neg(50);
    uv_lo = 1'b1;
    #1;
    chk("R4 hi off same cycle", drv_hi, 0);
    chk("R4 lo off same cycle", drv_lo, 0);
    wait_neg(10);
    chk("R4 hi off while active", drv_hi, 0);
    uv_lo = 1'b0;
    wait_neg(3);
    chk("R4 hi back without clear", drv_hi, 1);
    cmd_hi = 1'b0;
    wait_neg(50);
  endtask

  task automatic t_uvhi_r5_r6();
    cmd_hi = 1'b1;
    wait_neg(50);
    uv_hi = 1'b1;
    #1;
    chk("R5 hi off same cycle", drv_hi, 0);
    cmd_hi = 1'b0; cmd_lo = 1'b1;
    wait_neg(50);
    chk("R5 lo follows during uv_hi", drv_lo, 1);
    cmd_lo = 1'b0; cmd_hi = 1'b1;
    wait_neg(50);
    chk("R5 lo follows low during uv_hi", drv_lo, 0);
    chk("R6 hi off during uv_hi after edge", drv_hi, 0);
    uv_hi = 1'b0;
    wait_neg(50);
    chk("R6 hi stays off without fresh edge", drv_hi, 0);
    cmd_hi = 1'b0;
    wait_neg(10);
    cmd_hi = 1'b1;
    wait_neg(10);
    chk("R6 hi on after fresh edge", drv_hi, 1);
    cmd_hi = 1'b0;
    wait_neg(50);
  endtask

  task automatic t_freeze_r7();
    cmd_hi = 1'b1;
    wait_neg(50);
    freeze = 1'b1;
    cmd_hi = 1'b0; cmd_lo = 1'b1;
    wait_neg(50);
    chk("R7 hi held", drv_hi, 1);
    chk("R7 lo held", drv_lo, 0);
    freeze = 1'b0;
    wait_neg(60);
    chk("R7 hi follows after release", drv_hi, 0);
    chk("R7 lo follows after release", drv_lo, 1);
  endtask

  task automatic t_shdn_r8();
    freeze = 1'b1;
    shutdown = 1'b1;
    #1;
    chk("R8 lo off over freeze", drv_lo, 0);
    chk("R8 hi off", drv_hi, 0);
    wait_neg(10);
    shutdown = 1'b0;
    freeze = 1'b0;
    wait_neg(10);
    chk("R8 lo back without clear", drv_lo, 1);
    cmd_lo = 1'b0;
    wait_neg(50);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    t_reset_r10();
    t_follow_r3_r9();
    t_handover_r2(1'b1);
    t_handover_r2(1'b0);
    t_both_r1();
    t_uvlo_r4();
    t_uvhi_r5_r6();
    t_freeze_r7();
    t_shdn_r8();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule